// File: doc/BRIEF.md
# Preset-Reload Modulus Frequency Divider

This block divides its input clock by a fixed modulus and delivers the result as a clock enable. The counter does not count from zero and compare against a limit. It is loaded with a start value that sits exactly one modulus below the wrap point of an 8-bit count. It then counts up until its most significant slice reports a terminal carry. That carry is the divided output: it is high for one input clock in every `MODULUS` clocks, and the same cycle reloads the start value. The default modulus is 200.

The count is built from cascaded 4-bit up-counter slices. The low slice advances on every clock. Each higher slice advances only when every slice below it is at all ones. An external `preset` input is combined, active-low, with the terminal carry to form the load enable, so that `preset` forces the start value at any time. A toggle flip-flop follows the carry and produces a square wave with a 50% duty cycle at half the pulse rate. The pins carry no data stream, so there is no valid/ready handshake and every pin is a plain control or status signal.

Top module: `preset_mod_divider`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the counter takes the start value `2^8 - MODULUS`, and `div_square` is 0 after that edge. `div_pulse` stays 0 throughout reset.
- R2: In free running, `div_pulse` is high for exactly one clock cycle, and consecutive pulses are exactly `MODULUS` clock cycles apart.
- R3: After reset is released, the first `div_pulse` appears after `MODULUS-1` further rising edges, that is, in the `MODULUS`-th cycle counted from the first cycle out of reset.
- R4: While `preset` is held high, `div_pulse` stays 0 and `div_square` keeps its value.
- R5: After `preset` falls, the first `div_pulse` appears after `MODULUS-1` rising edges, counted from the last edge at which `preset` was high.
- R6: A single-cycle `preset` in the middle of a period discards the partial count and restarts the period with the timing of R5.
- R7: `div_square` inverts at each rising edge where `div_pulse` is high, including when `preset` is also high, and holds at every other edge. In free running this gives a period of `2*MODULUS` clocks with `MODULUS` clocks high.
- R8: `MODULUS` may be any value from 2 to 256. At `MODULUS = 2` the pulse is high on every second cycle and the square wave has a period of 4 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| preset | input | 1 | Active-high synchronous load of the start value |
| div_pulse | output | 1 | Terminal carry: one-cycle pulse every `MODULUS` clocks |
| div_square | output | 1 | 50% duty square wave that toggles on each pulse |

## Verification
The hardest case is a `preset` that arrives in the same cycle as the terminal carry. In that cycle the load from the input and the reload from the carry coincide, and the toggle still has to flip. Reaching that cycle from the ports requires counting to exactly `MODULUS-1` edges after a known reload. The bench therefore keeps a cycle-accurate phase model of the divider, steps exactly that many edges after a preset release, and then raises `preset` at the pulse. A second instance at `MODULUS = 2` runs alongside on the same stimulus. At that setting the reload happens on every other edge and the carry travels through both slices in every period.

// File: rtl/div_pkg.sv
package div_pkg;

  // Start value so that the count reaches all ones after modulus-1 steps.
  function automatic int unsigned div_start_value(int unsigned width, int unsigned modulus);
    return (32'd1 << width) - modulus;
  endfunction

endpackage

// File: rtl/div_count_slice.sv
module div_count_slice #(
  parameter int unsigned SLICE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [SLICE_W-1:0] load_val,
  input  logic               cin,
  output logic [SLICE_W-1:0] q,
  output logic               tc
);

  // Terminal carry: this slice is full and is being stepped from below.
  assign tc = cin & (&q);

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      q <= load_val;
    end else if (cin) begin
      q <= q + SLICE_W'(1);
    end
  end

  AST_SLICE_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !cin) |=> (q == $past(q))); // R2

endmodule

// File: rtl/div_toggle.sv
module div_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic t,
  output logic q
);

  logic d;

  // D flip-flop wired as a toggle: feed back the inverted output when t is high.
  assign d = t ? ~q : q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= d;
    end
  end

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    t |=> (q != $past(q))); // R7
  AST_TOGGLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !t |=> $stable(q)); // R7

endmodule

// File: rtl/preset_mod_divider.sv
module preset_mod_divider #(
  parameter int unsigned MODULUS    = 200,
  parameter int unsigned SLICE_W    = 4,
  parameter int unsigned NUM_SLICES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic preset,
  output logic div_pulse,
  output logic div_square
);

  import div_pkg::*;

  localparam int unsigned CNT_W = SLICE_W * NUM_SLICES;
  localparam logic [CNT_W-1:0] START = CNT_W'(div_start_value(CNT_W, MODULUS));

  logic [CNT_W-1:0]    count;
  logic [NUM_SLICES:0] carry;
  logic                load_n;
  logic                load;

  // Active-low load path: preset and the terminal carry are ANDed as lows.
  assign load_n = ~preset & ~div_pulse;
  assign load   = ~load_n;

  assign carry[0] = 1'b1;

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
    div_count_slice #(
      .SLICE_W (SLICE_W)
    ) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (START[g*SLICE_W +: SLICE_W]),
      .cin      (carry[g]),
      .q        (count[g*SLICE_W +: SLICE_W]),
      .tc       (carry[g+1])
    );
  end

  assign div_pulse = carry[NUM_SLICES];

  div_toggle u_toggle (
    .clk   (clk),
    .rst_n (rst_n),
    .t     (div_pulse),
    .q     (div_square)
  );

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse); // R2
  AST_RELOAD_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (div_pulse || preset) |=> (count == START)); // R6
  AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_pulse && !preset) |=> (count == $past(count) + CNT_W'(1))); // R2
  AST_PRESET_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> !div_pulse); // R4

endmodule

// File: tb/preset_mod_divider_bench.sv
module preset_mod_divider_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MOD_A = 200;
  localparam int MOD_B = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic preset;
  logic pulse_a, square_a, pulse_b, square_b;

  int checks = 0;
  int errors = 0;

  // Bench model state, derived from the requirements.
  int ph_a = 0, ph_b = 0;
  bit sq_a = 1'b0, sq_b = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  preset_mod_divider #(.MODULUS(MOD_A)) u_preset_mod_divider (
    .clk(clk), .rst_n(rst_n), .preset(preset),
    .div_pulse(pulse_a), .div_square(square_a)
  );

  preset_mod_divider #(.MODULUS(MOD_B)) u_small (
    .clk(clk), .rst_n(rst_n), .preset(preset),
    .div_pulse(pulse_b), .div_square(square_b)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Advance one rising edge, update the model, then compare at the falling edge.
  task automatic step(string ptag);
    bit pa, pb;
    string stag;
    pa = (ph_a == MOD_A - 1);
    pb = (ph_b == MOD_B - 1);
    if (!rst_n) begin
      ph_a = 0; sq_a = 1'b0; ph_b = 0; sq_b = 1'b0;
    end else begin
      if (pa) sq_a = ~sq_a;
      if (pb) sq_b = ~sq_b;
      ph_a = (preset || pa) ? 0 : ph_a + 1;
      ph_b = (preset || pb) ? 0 : ph_b + 1;
    end
    @(negedge clk);
    stag = (ptag == "R1") ? "R1" : "R7";
    check(ptag, "pulse", pulse_a, (rst_n && ph_a == MOD_A - 1));
    check(stag, "square", square_a, sq_a);
    check("R8", "small pulse", pulse_b, (rst_n && ph_b == MOD_B - 1));
    check("R8", "small square", square_b, sq_b);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; preset = 1'b0;
    for (int i = 0; i < 3; i++) step("R1");
    rst_n = 1'b1;
    for (int i = 0; i < MOD_A + 5; i++) step("R3");
  endtask

  task automatic t_free_run();
    for (int i = 0; i < 3 * 2 * MOD_A; i++) step("R2");
  endtask

  task automatic t_preset_hold();
    preset = 1'b1;
    for (int i = 0; i < 2 * MOD_A + 50; i++) step("R4");
    preset = 1'b0;
    for (int i = 0; i < MOD_A + 10; i++) step("R5");
  endtask

  task automatic t_preset_mid();
    for (int i = 0; i < 90; i++) step("R2");
    preset = 1'b1;
    step("R6");
    preset = 1'b0;
    for (int i = 0; i < MOD_A - 1; i++) step("R6");
    // Pulse is visible now: raise preset in the same cycle as the carry.
    check("R6", "pulse before coincident preset", pulse_a, 1'b1);
    preset = 1'b1;
    step("R7");
    preset = 1'b0;
    for (int i = 0; i < 2 * MOD_A + 10; i++) step("R6");
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 57; i++) step("R2");
    rst_n = 1'b0;
    for (int i = 0; i < 2; i++) step("R1");
    rst_n = 1'b1;
    for (int i = 0; i < MOD_A + 5; i++) step("R3");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    preset = 1'b0;
    t_reset();
    t_free_run();
    t_preset_hold();
    t_preset_mid();
    t_reset_mid();
    t_free_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule